// File: doc/BRIEF.md
# Single-to-Half Precision Rounding Converter

This unit takes one IEEE-754 binary32 operand per cycle and returns the matching binary16 encoding together with a five-bit exception vector. The caller supplies a two-bit rounding selector and a control that, when set, makes binary32 subnormal inputs behave as signed zeros. Results that fall below the smallest binary16 normal are always delivered as true subnormals and are never forced to zero. Exceptions are reported only and are never trapped.

The datapath re-biases the exponent and drops 13 fraction bits with guard and sticky collection. Tiny values take a right shift of the full significand. A single 15-bit increment then applies the rounding, and its carry may move into the exponent field. Special operands (NaN, infinity, zero, zeroed subnormal) bypass the arithmetic. Overflow replaces the result with infinity or with the largest finite magnitude, depending on direction.

Top module: `fp32_to_fp16_cvt`

## Requirements
- R1: With the default registered output, `outValid` is high exactly one cycle after `inValid` was high and low otherwise. `outData` and `outFlags` update on that same edge. An active-low reset drives `outValid`, `outData` and `outFlags` to zero.
- R2: A binary32 normal whose exponent field e lies in 113..142 maps to binary16 exponent e-112. Its fraction is cut to 10 bits and rounded to nearest with ties to even. A carry out of the fraction raises the exponent by one (0x3FFFF000 gives 0x4000).
- R3: `roundMode` encodes 00 nearest-even, 01 toward negative infinity, 10 toward positive infinity and 11 toward zero. A directed mode rounds the magnitude up only when the discarded bits are nonzero and the sign points in the chosen direction.
- R4: When the rounded magnitude reaches 2^16, the result is as follows. It is infinity for nearest-even. For toward zero it is sign|0x7BFF. For toward positive infinity it is 0x7C00 (positive) or 0xFBFF (negative). For toward negative infinity it is 0x7BFF (positive) or 0xFC00 (negative). Overflow and inexact are both raised.
- R5: Values below 2^-14 are shifted into binary16 subnormals and are never flushed. Underflow is raised when the value before rounding is below 2^-14 and the result is inexact; an exact tiny result raises nothing. Rounding up from the largest subnormal gives 0x0400.
- R6: With `dazEn` low, a binary32 subnormal input raises the denormal flag and is converted by its value. Such a value always rounds to a signed zero or to the smallest subnormal, with underflow and inexact.
- R7: With `dazEn` high, a binary32 subnormal input gives a signed zero with no flags at all. Normal inputs are unaffected by `dazEn`.
- R8: A NaN input yields {sign, 11111, 1, input fraction bits 21..13}. Invalid is raised only when input fraction bit 22 is clear (signalling NaN).
- R9: Infinities give sign|0x7C00, and zeros give sign|0x0000. Neither raises a flag.
- R10: `outFlags` bit 0 is invalid, bit 1 denormal, bit 2 overflow, bit 3 underflow and bit 4 inexact. Inexact is raised for a finite input exactly when discarded bits are nonzero or overflow occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand present this cycle |
| inData | input | 32 | binary32 operand |
| roundMode | input | 2 | Rounding selector |
| dazEn | input | 1 | Treat subnormal inputs as zero |
| outValid | output | 1 | Result present |
| outData | output | 16 | binary16 result |
| outFlags | output | 5 | Exception vector |

## Verification
The bench builds the converter with its default `OUT_REG` of 1 and the package's fixed binary32/binary16 field widths. In this setting every result lands exactly one edge after its operand, so a queue of expected items lines up with the output stream, including across an idle bubble. The fixed widths make the full exponent range reachable. The stimuli reach the subnormal shift cap, the carry into the top exponent, and both binary32 subnormal behaviours.

// File: rtl/fp_cvt_pkg.sv
package fp_cvt_pkg;
  localparam int SRC_W          = 32;
  localparam int SRC_EXP_W      = 8;
  localparam int SRC_MAN_W      = 23;
  localparam int SRC_BIAS       = 127;
  localparam int DST_W          = 16;
  localparam int DST_EXP_W      = 5;
  localparam int DST_MAN_W      = 10;
  localparam int DST_BIAS       = 15;
  localparam int BIAS_DIFF      = SRC_BIAS - DST_BIAS;
  localparam int MAN_DROP       = SRC_MAN_W - DST_MAN_W;
  localparam int SIG_W          = SRC_MAN_W + 1;
  localparam int SHIFT_CAP      = SIG_W + 2;
  localparam int SUB_EXT_W      = SHIFT_CAP + DST_MAN_W;
  localparam int SUB_SHIFT_BASE = SRC_BIAS + SRC_MAN_W - (DST_BIAS - 1 + DST_MAN_W);
  localparam int DST_EXP_TOP    = (1 << DST_EXP_W) - 1;

  localparam int FLAG_W        = 5;
  localparam int FLG_INVALID   = 0;
  localparam int FLG_DENORM    = 1;
  localparam int FLG_OVERFLOW  = 2;
  localparam int FLG_UNDERFLOW = 3;
  localparam int FLG_INEXACT   = 4;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_DOWN    = 2'b01,
    RM_UP      = 2'b10,
    RM_ZERO    = 2'b11
  } rndMode_e;

  typedef struct packed {
    logic selSub;
    logic bigExp;
    logic ovfToMax;
    logic forceNan;
    logic forceInf;
    logic forceZero;
  } cvtStrobe_t;
endpackage

// File: rtl/fp_cvt_ctrl.sv
module fp_cvt_ctrl
  import fp_cvt_pkg::*;
(
  input  logic [SRC_W-1:0]  srcBits,
  input  logic [1:0]        roundMode,
  input  logic              dazEn,
  input  logic              lsbBit,
  input  logic              guardBit,
  input  logic              stickyBit,
  input  logic              ovfHit,
  output cvtStrobe_t        strobe,
  output logic              roundUp,
  output logic [FLAG_W-1:0] flags
);
  logic                 sgn;
  logic [SRC_EXP_W-1:0] srcExp;
  logic [SRC_MAN_W-1:0] srcMan;
  rndMode_e             mode;
  logic expAllOnes, expZero, manZero;
  logic isNan, isInf, isZero, isSubIn, zeroed, finite, lostBits;

  assign {sgn, srcExp, srcMan} = srcBits;
  assign mode       = rndMode_e'(roundMode);
  assign expAllOnes = &srcExp;
  assign expZero    = (srcExp == '0);
  assign manZero    = (srcMan == '0);
  assign isNan      = expAllOnes & ~manZero;
  assign isInf      = expAllOnes & manZero;
  assign isZero     = expZero & manZero;
  assign isSubIn    = expZero & ~manZero;
  assign zeroed     = isZero | (isSubIn & dazEn);
  assign finite     = ~expAllOnes & ~zeroed;
  assign lostBits   = guardBit | stickyBit;

  // static decode, depends on the operand and controls only
  always_comb begin
    strobe.forceNan  = isNan;
    strobe.forceInf  = isInf;
    strobe.forceZero = zeroed;
    strobe.selSub    = finite & (srcExp <= SRC_EXP_W'(BIAS_DIFF));
    strobe.bigExp    = finite & (srcExp >= SRC_EXP_W'(BIAS_DIFF + DST_EXP_TOP));
    case (mode)
      RM_NEAREST: strobe.ovfToMax = 1'b0;
      RM_DOWN:    strobe.ovfToMax = ~sgn;
      RM_UP:      strobe.ovfToMax = sgn;
      default:    strobe.ovfToMax = 1'b1;
    endcase
  end

  // increment decision from the datapath's discarded bits
  always_comb begin
    case (mode)
      RM_NEAREST: roundUp = guardBit & (stickyBit | lsbBit);
      RM_DOWN:    roundUp = sgn & lostBits;
      RM_UP:      roundUp = ~sgn & lostBits;
      default:    roundUp = 1'b0;
    endcase
  end

  always_comb begin
    flags                = '0;
    flags[FLG_INVALID]   = isNan & ~srcMan[SRC_MAN_W-1];
    flags[FLG_DENORM]    = isSubIn & ~dazEn;
    flags[FLG_OVERFLOW]  = finite & ovfHit;
    flags[FLG_UNDERFLOW] = finite & strobe.selSub & lostBits;
    flags[FLG_INEXACT]   = finite & (lostBits | ovfHit);
  end
endmodule

// File: rtl/fp_cvt_dp.sv
module fp_cvt_dp
  import fp_cvt_pkg::*;
(
  input  logic [SRC_W-1:0] srcBits,
  input  cvtStrobe_t       strobe,
  input  logic             roundUp,
  output logic             lsbBit,
  output logic             guardBit,
  output logic             stickyBit,
  output logic             ovfHit,
  output logic [DST_W-1:0] resBits
);
  logic                 sgn;
  logic [SRC_EXP_W-1:0] srcExp;
  logic [SRC_MAN_W-1:0] srcMan;
  logic [SIG_W-1:0]     sig;
  logic [SRC_EXP_W-1:0] effExp, shRaw, shAmt;
  logic [SUB_EXT_W-1:0] subExt;
  logic [DST_EXP_W-1:0] expPre;
  logic [DST_MAN_W-1:0] mantPre;
  logic [DST_W-2:0]     roundSum;

  assign {sgn, srcExp, srcMan} = srcBits;
  assign sig = {srcExp != '0, srcMan};

  // right shift that lands a tiny value on the binary16 subnormal grid
  always_comb begin
    effExp = (srcExp == '0) ? SRC_EXP_W'(1) : srcExp;
    shRaw  = SRC_EXP_W'(SUB_SHIFT_BASE) - effExp;
    shAmt  = (shRaw > SRC_EXP_W'(SHIFT_CAP)) ? SRC_EXP_W'(SHIFT_CAP) : shRaw;
  end
  assign subExt = SUB_EXT_W'({sig, {SHIFT_CAP{1'b0}}} >> shAmt);

  always_comb begin
    if (strobe.selSub) begin
      expPre    = '0;
      mantPre   = subExt[SUB_EXT_W-1:SHIFT_CAP];
      guardBit  = subExt[SHIFT_CAP-1];
      stickyBit = |subExt[SHIFT_CAP-2:0];
    end else begin
      expPre    = DST_EXP_W'(srcExp - SRC_EXP_W'(BIAS_DIFF));
      mantPre   = srcMan[SRC_MAN_W-1:MAN_DROP];
      guardBit  = srcMan[MAN_DROP-1];
      stickyBit = |srcMan[MAN_DROP-2:0];
    end
  end
  assign lsbBit = mantPre[0];

  // one adder: a fraction carry walks into the exponent field
  assign roundSum = {expPre, mantPre} + (DST_W-1)'(roundUp);
  assign ovfHit   = strobe.bigExp |
                    (roundSum[DST_W-2:DST_MAN_W] == DST_EXP_W'(DST_EXP_TOP));

  always_comb begin
    if (strobe.forceNan)
      resBits = {sgn, {DST_EXP_W{1'b1}}, 1'b1, srcMan[SRC_MAN_W-2 -: DST_MAN_W-1]};
    else if (strobe.forceInf)
      resBits = {sgn, {DST_EXP_W{1'b1}}, {DST_MAN_W{1'b0}}};
    else if (strobe.forceZero)
      resBits = {sgn, {(DST_W-1){1'b0}}};
    else if (ovfHit && strobe.ovfToMax)
      resBits = {sgn, DST_EXP_W'(DST_EXP_TOP - 1), {DST_MAN_W{1'b1}}};
    else if (ovfHit)
      resBits = {sgn, {DST_EXP_W{1'b1}}, {DST_MAN_W{1'b0}}};
    else
      resBits = {sgn, roundSum};
  end
endmodule

// File: rtl/fp32_to_fp16_cvt.sv
module fp32_to_fp16_cvt
  import fp_cvt_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [SRC_W-1:0]  inData,
  input  logic [1:0]        roundMode,
  input  logic              dazEn,
  output logic              outValid,
  output logic [DST_W-1:0]  outData,
  output logic [FLAG_W-1:0] outFlags
);
  cvtStrobe_t        strobe;
  logic              roundUp, lsbBit, guardBit, stickyBit, ovfHit;
  logic [DST_W-1:0]  resBits;
  logic [FLAG_W-1:0] flags;

  fp_cvt_ctrl u_ctrl (
    .srcBits   (inData),
    .roundMode (roundMode),
    .dazEn     (dazEn),
    .lsbBit    (lsbBit),
    .guardBit  (guardBit),
    .stickyBit (stickyBit),
    .ovfHit    (ovfHit),
    .strobe    (strobe),
    .roundUp   (roundUp),
    .flags     (flags)
  );

  fp_cvt_dp u_dp (
    .srcBits   (inData),
    .strobe    (strobe),
    .roundUp   (roundUp),
    .lsbBit    (lsbBit),
    .guardBit  (guardBit),
    .stickyBit (stickyBit),
    .ovfHit    (ovfHit),
    .resBits   (resBits)
  );

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          outValid <= 1'b0;
          outData  <= '0;
          outFlags <= '0;
        end else begin
          outValid <= inValid;
          outData  <= resBits;
          outFlags <= flags;
        end
      end

      AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rstN)
        inValid |=> outValid);  // R1
      AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> !outValid);  // R1
      AST_OVF_INEXACT: assert property (@(posedge clk) disable iff (!rstN)
        (outValid && outFlags[FLG_OVERFLOW]) |-> outFlags[FLG_INEXACT]);  // R4
      AST_UNF_INEXACT: assert property (@(posedge clk) disable iff (!rstN)
        (outValid && outFlags[FLG_UNDERFLOW]) |-> outFlags[FLG_INEXACT]);  // R5
      AST_DAZ_SILENT: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && dazEn) |=> !outFlags[FLG_DENORM]);  // R7
      AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
        (outValid && (&outData[DST_W-2:DST_MAN_W]) && (outData[DST_MAN_W-1:0] != '0))
          |-> outData[DST_MAN_W-1]);  // R8
      AST_INF_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && (&inData[SRC_W-2:SRC_MAN_W]) && (inData[SRC_MAN_W-1:0] == '0))
          |=> (outData == {$past(inData[SRC_W-1]), {DST_EXP_W{1'b1}}, {DST_MAN_W{1'b0}}}
               && outFlags == '0));  // R9
    end else begin : g_comb
      assign outValid = inValid;
      assign outData  = resBits;
      assign outFlags = flags;
    end
  endgenerate
endmodule

// File: tb/test_fp32_to_fp16_cvt.sv
module test_fp32_to_fp16_cvt;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inData = '0;
  logic [1:0]  roundMode = 2'b00;
  logic        dazEn = 1'b0;
  logic        outValid;
  logic [15:0] outData;
  logic [4:0]  outFlags;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [15:0] d;
    logic [4:0]  f;
    string       tag;
  } expItem_t;
  expItem_t sb[$];

  always #10 clk = ~clk;

  fp32_to_fp16_cvt i_fp32_to_fp16_cvt (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inData    (inData),
    .roundMode (roundMode),
    .dazEn     (dazEn),
    .outValid  (outValid),
    .outData   (outData),
    .outFlags  (outFlags)
  );

  // driver: one operand per call, expected item goes to the scoreboard
  task automatic send(input logic [31:0] a, input logic [1:0] rm, input logic daz,
                      input logic [15:0] expD, input logic [4:0] expF, input string tag);
    expItem_t it;
    @(negedge clk);
    inValid   = 1'b1;
    inData    = a;
    roundMode = rm;
    dazEn     = daz;
    it.d = expD; it.f = expF; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // monitor: compare away from the active edge
  always @(posedge clk) begin
    #5;
    if (rstN && outValid) begin
      checks++;
      if (sb.size() == 0) begin
        failures++;
        $display("FAIL R1 unexpected result data=%h flags=%b expected none", outData, outFlags);
      end else begin
        expItem_t it;
        it = sb.pop_front();
        if (outData !== it.d || outFlags !== it.f) begin
          failures++;
          $display("FAIL %s data=%h flags=%b expected data=%h flags=%b",
                   it.tag, outData, outFlags, it.d, it.f);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired with %0d items pending", sb.size());
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(posedge clk); #5;
    checks++;
    if (outValid !== 1'b0 || outData !== 16'h0 || outFlags !== 5'h0) begin
      failures++;
      $display("FAIL R1 reset state valid=%b data=%h flags=%b expected 0/0000/00000",
               outValid, outData, outFlags);
    end
    @(negedge clk);
    rstN = 1'b1;

    // R2 normal range, nearest-even
    send(32'h3F800000, 2'b00, 1'b0, 16'h3C00, 5'h00, "R2 one");
    send(32'hC0200000, 2'b00, 1'b0, 16'hC100, 5'h00, "R2 minus 2.5");
    send(32'h3F801000, 2'b00, 1'b0, 16'h3C00, 5'h10, "R2 tie to even down");
    send(32'h3F803000, 2'b00, 1'b0, 16'h3C02, 5'h10, "R2 tie to even up");
    send(32'h3FFFF000, 2'b00, 1'b0, 16'h4000, 5'h10, "R2 fraction carry");
    // R10 exact vs inexact
    send(32'h3F802000, 2'b00, 1'b0, 16'h3C01, 5'h00, "R10 exact no inexact");
    // R3 directed modes
    send(32'h3F800001, 2'b00, 1'b0, 16'h3C00, 5'h10, "R3 nearest");
    send(32'h3F800001, 2'b10, 1'b0, 16'h3C01, 5'h10, "R3 up positive");
    send(32'h3F800001, 2'b01, 1'b0, 16'h3C00, 5'h10, "R3 down positive");
    send(32'h3F800001, 2'b11, 1'b0, 16'h3C00, 5'h10, "R3 zero positive");
    send(32'hBF800001, 2'b01, 1'b0, 16'hBC01, 5'h10, "R3 down negative");
    send(32'hBF800001, 2'b10, 1'b0, 16'hBC00, 5'h10, "R3 up negative");
    idle();
    @(posedge clk); #5;
    checks++;
    if (outValid !== 1'b0) begin
      failures++;
      $display("FAIL R1 valid after bubble=%b expected 0", outValid);
    end
    // R4 overflow
    send(32'h477FE000, 2'b00, 1'b0, 16'h7BFF, 5'h00, "R4 largest exact");
    send(32'h477FF000, 2'b00, 1'b0, 16'h7C00, 5'h14, "R4 carry to inf");
    send(32'h477FF000, 2'b11, 1'b0, 16'h7BFF, 5'h10, "R4 truncate below limit");
    send(32'h477FE001, 2'b10, 1'b0, 16'h7C00, 5'h14, "R4 up crosses limit");
    send(32'h501502F9, 2'b10, 1'b0, 16'h7C00, 5'h14, "R4 big up positive");
    send(32'h501502F9, 2'b01, 1'b0, 16'h7BFF, 5'h14, "R4 big down positive");
    send(32'h501502F9, 2'b11, 1'b0, 16'h7BFF, 5'h14, "R4 big zero positive");
    send(32'hD01502F9, 2'b01, 1'b0, 16'hFC00, 5'h14, "R4 big down negative");
    send(32'hD01502F9, 2'b10, 1'b0, 16'hFBFF, 5'h14, "R4 big up negative");
    // R5 subnormal outputs
    send(32'h33800000, 2'b00, 1'b0, 16'h0001, 5'h00, "R5 smallest subnormal exact");
    send(32'h38000000, 2'b00, 1'b0, 16'h0200, 5'h00, "R5 half of min normal");
    send(32'h387FF000, 2'b00, 1'b0, 16'h0400, 5'h18, "R5 carry to min normal");
    send(32'h387FF000, 2'b11, 1'b0, 16'h03FF, 5'h18, "R5 largest subnormal");
    send(32'h33000000, 2'b00, 1'b0, 16'h0000, 5'h18, "R5 tie to zero");
    send(32'h33000000, 2'b10, 1'b0, 16'h0001, 5'h18, "R5 up to min subnormal");
    send(32'h38800000, 2'b00, 1'b0, 16'h0400, 5'h00, "R5 min normal exact");
    // R6 subnormal input, DAZ clear
    send(32'h00000001, 2'b00, 1'b0, 16'h0000, 5'h1A, "R6 tiny nearest");
    send(32'h00000001, 2'b10, 1'b0, 16'h0001, 5'h1A, "R6 tiny up");
    send(32'h80400000, 2'b01, 1'b0, 16'h8001, 5'h1A, "R6 negative down");
    // R7 DAZ set
    send(32'h00000001, 2'b10, 1'b1, 16'h0000, 5'h00, "R7 zeroed positive");
    send(32'h80400000, 2'b01, 1'b1, 16'h8000, 5'h00, "R7 zeroed negative");
    send(32'h3F800000, 2'b00, 1'b1, 16'h3C00, 5'h00, "R7 normal unaffected");
    // R8 NaNs
    send(32'h7F812345, 2'b00, 1'b0, 16'h7E09, 5'h01, "R8 signalling payload");
    send(32'hFF800001, 2'b00, 1'b0, 16'hFE00, 5'h01, "R8 signalling low payload");
    send(32'h7FC00000, 2'b00, 1'b0, 16'h7E00, 5'h00, "R8 quiet");
    send(32'hFFE00000, 2'b11, 1'b0, 16'hFF00, 5'h00, "R8 quiet payload");
    // R9 infinities and zeros
    send(32'h7F800000, 2'b00, 1'b0, 16'h7C00, 5'h00, "R9 plus inf");
    send(32'hFF800000, 2'b11, 1'b0, 16'hFC00, 5'h00, "R9 minus inf");
    send(32'h80000000, 2'b00, 1'b0, 16'h8000, 5'h00, "R9 minus zero");
    send(32'h00000000, 2'b10, 1'b1, 16'h0000, 5'h00, "R9 plus zero");
    idle();

    for (int w = 0; w < 20 && sb.size() != 0; w++) @(posedge clk);
    #6;
    if (sb.size() != 0) begin
      failures++;
      $display("FAIL R1 %0d results missing expected 0", sb.size());
    end
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule